// File: doc/BRIEF.md
# Oldest-First Issue Selector with Countdown Scoreboard

This block chooses which micro-ops in an out-of-order instruction window begin execution in the current cycle. The window is held outside the block and is presented with slot 0 as the oldest entry. Each cycle the block picks at most `N` slots that are valid, not yet issued and eligible, and it favours lower slot indices. For every granted slot it reports the cycle in which the result will be complete. The surrounding window records the issued flag and that cycle.

Eligibility comes from a scoreboard that the block owns. It holds one small signed countdown per physical register:

- Zero means the value is available.
- Minus one means the producer has been renamed but has not issued.
- A positive value counts the cycles left until the result appears.

Renaming sets a destination to minus one. Issuing sets it to the producer's latency. Every positive count falls by one at each clock.

Loads can also be held back behind older stores. A two-bit mode chooses the rule: no ordering, conservative ordering (any older unfinished store), or ordering only against older unfinished stores to the same address.

Top module: `oldest_first_issue`

## Requirements
- R1: During reset, every scoreboard entry reads zero and the cycle counter `cyc` reads zero.
- R2: A register named on a valid rename lane reads minus one (all ones in the `SB_W`-bit two's complement entry) after the next clock edge.
- R3: A granted slot's `grant_done_at` equals `cyc` plus its latency: 3 when `slot_load` is set, otherwise 1. Each valid destination of that slot reads latency minus one after the clock edge. `cyc` rises by one per clock.
- R4: At each clock, a positive scoreboard entry that is not rewritten falls by one. Zero and negative entries that are not rewritten keep their value.
- R5: A slot is eligible only if every source whose valid bit is set names a register whose entry is zero. Sources whose valid bit is clear have no effect.
- R6: Slot 0 is the oldest. The grants go to the first `N` eligible slots in ascending index order, and to no others.
- R7: With `ord_mode` = 0, loads are never held by stores.
- R8: With `ord_mode` = 1 or 3, a load is held while any valid store in a lower-index slot is not done. A store is done when `slot_issued` is set and `cyc` minus `slot_done_at`, taken modulo 2^CW, has its top bit clear.
- R9: With `ord_mode` = 2, a load is held only by a valid, not-done store in a lower-index slot whose `slot_addr` equals the load's address. Stores in higher-index slots never hold a load.
- R10: A slot with `slot_vld` clear or `slot_issued` set is never granted.
- R11: A rename write to a register takes precedence over a same-cycle issue write or decrement of that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ord_mode | input | 2 | Load ordering rule: 0 none, 1 or 3 conservative, 2 address-matched |
| slot_vld | input | WIN | Slot holds a micro-op |
| slot_issued | input | WIN | Slot has already issued |
| slot_load | input | WIN | Slot is a load |
| slot_store | input | WIN | Slot is a store |
| slot_src_vld | input | WIN*NSRC | Per-source valid bits |
| slot_src | input | WIN*NSRC*PW | Source physical register numbers |
| slot_dst_vld | input | WIN*NDST | Per-destination valid bits |
| slot_dst | input | WIN*NDST*PW | Destination physical register numbers |
| slot_addr | input | WIN*AW | Memory address of loads and stores |
| slot_done_at | input | WIN*CW | Recorded completion cycle of issued slots |
| ren_vld | input | REN_W | Rename lane valid |
| ren_dst | input | REN_W*PW | Register named by each rename lane |
| grant | output | WIN | Slot selected to issue this cycle |
| grant_done_at | output | WIN*CW | Completion cycle for each granted slot |
| cyc | output | CW | Wrapping cycle counter |
| sb_state | output | NPREG*SB_W | Scoreboard entries, signed, register r at bits r*SB_W |

## Verification
The checker relies on the window never presenting a slot as issued without a matching completion cycle. It also assumes that the distance between `cyc` and any recorded completion cycle stays under half the counter range, so the wrapped comparison is meaningful. The bench respects both conditions: it sets completion cycles only within a few cycles of the current one. It also never renames a register whose producer is still pending, except in the single case that checks rename precedence. Grant patterns are swept over all 256 valid and eligibility masks, and over every ordering mode against each store state and address relation. Slots in these sweeps carry no destinations, so the scoreboard stays fixed during the sweep.

// File: rtl/isq_pkg.sv
// Shared definitions for the oldest-first issue selector.
// Assumes: mode encodings are fixed by the window that drives them.
package isq_pkg;

    typedef enum logic [1:0] {
        ORD_NONE = 2'd0,
        ORD_CONS = 2'd1,
        ORD_ADDR = 2'd2,
        ORD_CONS2 = 2'd3
    } ord_mode_e;

endpackage

// File: rtl/isq_scoreboard.sv
// Per-physical-register signed countdown table.
// Rename writes -1, issue writes latency-1, positive entries fall by one
// each clock. Rename has the final word on a register in a cycle.
// Assumes: register count is a power of two so PW-bit indices cover it.
module isq_scoreboard #(
    parameter int NPREG  = 16,
    parameter int PW     = 4,
    parameter int SB_W   = 3,
    parameter int WIN    = 8,
    parameter int NDST   = 2,
    parameter int REN_W  = 2,
    parameter int LAT_LD = 3,
    parameter int LAT_OP = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [WIN-1:0]          grant,
    input  logic [WIN-1:0]          is_load,
    input  logic [WIN*NDST-1:0]     dst_vld,
    input  logic [WIN*NDST*PW-1:0]  dst,
    input  logic [REN_W-1:0]        ren_vld,
    input  logic [REN_W*PW-1:0]     ren_dst,
    output logic [NPREG*SB_W-1:0]   sb_flat
);

    localparam logic [SB_W-1:0] LD_VAL = SB_W'(LAT_LD - 1);
    localparam logic [SB_W-1:0] OP_VAL = SB_W'(LAT_OP - 1);
    localparam logic [SB_W-1:0] NEG1   = '1;

    logic signed [SB_W-1:0] sb_q [NPREG];
    logic signed [SB_W-1:0] sb_d [NPREG];

    // Next value per register: decay, then issue writes, then rename writes.
    always_comb begin
        for (int r = 0; r < NPREG; r++) begin
            sb_d[r] = sb_q[r];
            if (sb_q[r] > 0) sb_d[r] = sb_q[r] - SB_W'(1);
            for (int w = 0; w < WIN; w++) begin
                for (int d = 0; d < NDST; d++) begin
                    if (grant[w] && dst_vld[w*NDST+d] &&
                        dst[(w*NDST+d)*PW +: PW] == PW'(r))
                        sb_d[r] = is_load[w] ? LD_VAL : OP_VAL;
                end
            end
            for (int k = 0; k < REN_W; k++) begin
                if (ren_vld[k] && ren_dst[k*PW +: PW] == PW'(r))
                    sb_d[r] = NEG1;
            end
        end
    end

    // Table storage with synchronous clear.
    always_ff @(posedge clk) begin
        for (int r = 0; r < NPREG; r++) begin
            if (!rst_n) sb_q[r] <= '0;
            else        sb_q[r] <= sb_d[r];
        end
    end

    generate
        for (genvar r = 0; r < NPREG; r++) begin : g_out
            assign sb_flat[r*SB_W +: SB_W] = sb_q[r];
        end
    endgenerate

endmodule

// File: rtl/isq_ready.sv
// Per-slot eligibility: valid, not issued, all valid sources at zero, and
// not held by an older unfinished store under the selected ordering mode.
// Assumes: slot 0 is oldest; completion cycles lie within half the counter
// range of the current cycle.
module isq_ready
    import isq_pkg::*;
#(
    parameter int WIN   = 8,
    parameter int NSRC  = 3,
    parameter int NPREG = 16,
    parameter int PW    = 4,
    parameter int SB_W  = 3,
    parameter int AW    = 16,
    parameter int CW    = 8
) (
    input  ord_mode_e               mode,
    input  logic [CW-1:0]           cyc,
    input  logic [WIN-1:0]          valid,
    input  logic [WIN-1:0]          issued,
    input  logic [WIN-1:0]          is_load,
    input  logic [WIN-1:0]          is_store,
    input  logic [WIN*NSRC-1:0]     src_vld,
    input  logic [WIN*NSRC*PW-1:0]  src,
    input  logic [WIN*AW-1:0]       addr,
    input  logic [WIN*CW-1:0]       done_at,
    input  logic [NPREG*SB_W-1:0]   sb_flat,
    output logic [WIN-1:0]          ready
);

    logic [NPREG-1:0] sb_zero;
    logic [WIN-1:0]   done;

    generate
        for (genvar r = 0; r < NPREG; r++) begin : g_zero
            assign sb_zero[r] = (sb_flat[r*SB_W +: SB_W] == '0);
        end

        for (genvar j = 0; j < WIN; j++) begin : g_done
            logic [CW-1:0] gap;
            assign gap     = cyc - done_at[j*CW +: CW];
            assign done[j] = issued[j] && !gap[CW-1];
        end

        for (genvar i = 0; i < WIN; i++) begin : g_slot
            logic src_ok;
            logic mem_ok;
            // Source readiness and memory-ordering hold for slot i.
            always_comb begin
                src_ok = 1'b1;
                for (int s = 0; s < NSRC; s++) begin
                    if (src_vld[i*NSRC+s] && !sb_zero[src[(i*NSRC+s)*PW +: PW]])
                        src_ok = 1'b0;
                end
                mem_ok = 1'b1;
                if (is_load[i] && mode != ORD_NONE) begin
                    for (int j = 0; j < i; j++) begin
                        if (valid[j] && is_store[j] && !done[j] &&
                            (mode != ORD_ADDR ||
                             addr[j*AW +: AW] == addr[i*AW +: AW]))
                            mem_ok = 1'b0;
                    end
                end
            end
            assign ready[i] = valid[i] && !issued[i] && src_ok && mem_ok;
        end
    endgenerate

endmodule

// File: rtl/isq_select.sv
// Grants the first N eligible slots in ascending index (oldest-first) order.
// Assumes: eligibility is already final for this cycle.
module isq_select #(
    parameter int WIN = 8,
    parameter int N   = 2
) (
    input  logic [WIN-1:0] ready,
    output logic [WIN-1:0] grant
);

    localparam int CNT_W = $clog2(WIN + 1);

    logic [CNT_W-1:0] taken;

    // Running count of grants given to older slots.
    always_comb begin
        taken = '0;
        for (int i = 0; i < WIN; i++) begin
            grant[i] = 1'b0;
            if (ready[i] && 32'(taken) < N) begin
                grant[i] = 1'b1;
                taken    = taken + 1'b1;
            end
        end
    end

endmodule

// File: rtl/oldest_first_issue.sv
// Top of the issue selector: cycle counter, eligibility, oldest-first pick,
// completion cycles for grants, and the countdown scoreboard.
// Assumes: the window marks granted slots issued and stores grant_done_at.
module oldest_first_issue
    import isq_pkg::*;
#(
    parameter int WIN    = 8,
    parameter int N      = 2,
    parameter int NPREG  = 16,
    parameter int NSRC   = 3,
    parameter int NDST   = 2,
    parameter int REN_W  = 2,
    parameter int AW     = 16,
    parameter int CW     = 8,
    parameter int LAT_LD = 3,
    parameter int LAT_OP = 1,
    localparam int PW    = $clog2(NPREG),
    localparam int SB_W  = $clog2(LAT_LD) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              ord_mode,
    input  logic [WIN-1:0]          slot_vld,
    input  logic [WIN-1:0]          slot_issued,
    input  logic [WIN-1:0]          slot_load,
    input  logic [WIN-1:0]          slot_store,
    input  logic [WIN*NSRC-1:0]     slot_src_vld,
    input  logic [WIN*NSRC*PW-1:0]  slot_src,
    input  logic [WIN*NDST-1:0]     slot_dst_vld,
    input  logic [WIN*NDST*PW-1:0]  slot_dst,
    input  logic [WIN*AW-1:0]       slot_addr,
    input  logic [WIN*CW-1:0]       slot_done_at,
    input  logic [REN_W-1:0]        ren_vld,
    input  logic [REN_W*PW-1:0]     ren_dst,
    output logic [WIN-1:0]          grant,
    output logic [WIN*CW-1:0]       grant_done_at,
    output logic [CW-1:0]           cyc,
    output logic [NPREG*SB_W-1:0]   sb_state
);

    logic [WIN-1:0] ready;
    ord_mode_e      mode;

    assign mode = ord_mode_e'(ord_mode);

    // Free-running wrapping cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= cyc + 1'b1;
    end

    generate
        for (genvar i = 0; i < WIN; i++) begin : g_done
            assign grant_done_at[i*CW +: CW] =
                cyc + (slot_load[i] ? CW'(LAT_LD) : CW'(LAT_OP));
        end
    endgenerate

    isq_ready #(
        .WIN(WIN), .NSRC(NSRC), .NPREG(NPREG), .PW(PW),
        .SB_W(SB_W), .AW(AW), .CW(CW)
    ) u_ready (
        .mode(mode), .cyc(cyc), .valid(slot_vld), .issued(slot_issued),
        .is_load(slot_load), .is_store(slot_store),
        .src_vld(slot_src_vld), .src(slot_src), .addr(slot_addr),
        .done_at(slot_done_at), .sb_flat(sb_state), .ready(ready)
    );

    isq_select #(.WIN(WIN), .N(N)) u_sel (
        .ready(ready), .grant(grant)
    );

    isq_scoreboard #(
        .NPREG(NPREG), .PW(PW), .SB_W(SB_W), .WIN(WIN), .NDST(NDST),
        .REN_W(REN_W), .LAT_LD(LAT_LD), .LAT_OP(LAT_OP)
    ) u_sb (
        .clk(clk), .rst_n(rst_n), .grant(grant), .is_load(slot_load),
        .dst_vld(slot_dst_vld), .dst(slot_dst),
        .ren_vld(ren_vld), .ren_dst(ren_dst), .sb_flat(sb_state)
    );

endmodule

// File: rtl/isq_chk.sv
// Assertion checker for oldest_first_issue, attached by bind.
// Assumes: inputs change only between clock edges.
module isq_chk #(
    parameter int WIN   = 8,
    parameter int N     = 2,
    parameter int NPREG = 16,
    parameter int NSRC  = 3,
    parameter int REN_W = 2,
    parameter int PW    = 4,
    parameter int SB_W  = 3,
    parameter int CW    = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [WIN-1:0]          slot_vld,
    input logic [WIN-1:0]          slot_issued,
    input logic [WIN*NSRC-1:0]     slot_src_vld,
    input logic [WIN*NSRC*PW-1:0]  slot_src,
    input logic [REN_W-1:0]        ren_vld,
    input logic [REN_W*PW-1:0]     ren_dst,
    input logic [WIN-1:0]          grant,
    input logic [CW-1:0]           cyc,
    input logic [NPREG*SB_W-1:0]   sb_state
);

    function automatic logic [SB_W-1:0] sb_at(input logic [PW-1:0] idx);
        return sb_state[idx*SB_W +: SB_W];
    endfunction

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sb_state == '0 && cyc == '0));

    a_r3_clock_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cyc == $past(cyc) + 1'b1);

    a_r6_width: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) <= N);

    a_r10_no_stale: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~(slot_vld & ~slot_issued)) == '0);

    generate
        for (genvar i = 0; i < WIN; i++) begin : g_src
            for (genvar s = 0; s < NSRC; s++) begin : g_s
                a_r5_src_zero: assert property (@(posedge clk) disable iff (!rst_n)
                    (grant[i] && slot_src_vld[i*NSRC+s]) |->
                    sb_at(slot_src[(i*NSRC+s)*PW +: PW]) == '0);
            end
        end

        for (genvar k = 0; k < REN_W; k++) begin : g_ren
            a_r2_rename_neg: assert property (@(posedge clk) disable iff (!rst_n)
                ren_vld[k] |=> sb_at($past(ren_dst[k*PW +: PW])) == '1);
        end

        for (genvar r = 0; r < NPREG; r++) begin : g_decay
            logic signed [SB_W-1:0] v;
            assign v = sb_state[r*SB_W +: SB_W];
            a_r4_decay: assert property (@(posedge clk) disable iff (!rst_n)
                (v > 0 && grant == '0 && ren_vld == '0) |=> v == $past(v) - SB_W'(1));
        end
    endgenerate

endmodule

bind oldest_first_issue isq_chk #(
    .WIN(WIN), .N(N), .NPREG(NPREG), .NSRC(NSRC), .REN_W(REN_W),
    .PW(PW), .SB_W(SB_W), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_issued(slot_issued),
    .slot_src_vld(slot_src_vld), .slot_src(slot_src),
    .ren_vld(ren_vld), .ren_dst(ren_dst),
    .grant(grant), .cyc(cyc), .sb_state(sb_state)
);

// File: tb/sim_oldest_first_issue.sv
module sim_oldest_first_issue;

    localparam int W = 8, NS = 3, ND = 2, P = 4, A = 16, C = 8, RW = 2, SBW = 3, NG = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] ord_mode;
    logic [W-1:0] slot_vld, slot_issued, slot_load, slot_store;
    logic [W*NS-1:0] slot_src_vld;
    logic [W*NS*P-1:0] slot_src;
    logic [W*ND-1:0] slot_dst_vld;
    logic [W*ND*P-1:0] slot_dst;
    logic [W*A-1:0] slot_addr;
    logic [W*C-1:0] slot_done_at;
    logic [RW-1:0] ren_vld;
    logic [RW*P-1:0] ren_dst;
    logic [W-1:0] grant;
    logic [W*C-1:0] grant_done_at;
    logic [C-1:0] cyc;
    logic [16*SBW-1:0] sb_state;

    logic [NS-1:0] b_svld [W];
    logic [P-1:0]  b_src  [W][NS];
    logic [ND-1:0] b_dvld [W];
    logic [P-1:0]  b_dst  [W][ND];
    logic [A-1:0]  b_addr [W];
    logic [C-1:0]  b_done [W];
    logic [C-1:0]  bcyc;

    int nchk = 0, nfail = 0;

    always #10 clk = ~clk;

    always @(posedge clk) bcyc <= rst_n ? bcyc + 1'b1 : '0;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            for (int s = 0; s < NS; s++) begin
                slot_src_vld[i*NS+s] = b_svld[i][s];
                slot_src[(i*NS+s)*P +: P] = b_src[i][s];
            end
            for (int d = 0; d < ND; d++) begin
                slot_dst_vld[i*ND+d] = b_dvld[i][d];
                slot_dst[(i*ND+d)*P +: P] = b_dst[i][d];
            end
            slot_addr[i*A +: A] = b_addr[i];
            slot_done_at[i*C +: C] = b_done[i];
        end
    end

    oldest_first_issue u0 (
        .clk(clk), .rst_n(rst_n), .ord_mode(ord_mode),
        .slot_vld(slot_vld), .slot_issued(slot_issued),
        .slot_load(slot_load), .slot_store(slot_store),
        .slot_src_vld(slot_src_vld), .slot_src(slot_src),
        .slot_dst_vld(slot_dst_vld), .slot_dst(slot_dst),
        .slot_addr(slot_addr), .slot_done_at(slot_done_at),
        .ren_vld(ren_vld), .ren_dst(ren_dst), .grant(grant),
        .grant_done_at(grant_done_at), .cyc(cyc), .sb_state(sb_state)
    );

    function automatic logic [SBW-1:0] sbv(input int r);
        return sb_state[r*SBW +: SBW];
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_win();
        ord_mode = 2'd0;
        slot_vld = '0; slot_issued = '0; slot_load = '0; slot_store = '0;
        ren_vld = '0; ren_dst = '0;
        for (int i = 0; i < W; i++) begin
            b_svld[i] = '0; b_dvld[i] = '0; b_addr[i] = '0; b_done[i] = '0;
            for (int s = 0; s < NS; s++) b_src[i][s] = '0;
            for (int d = 0; d < ND; d++) b_dst[i][d] = '0;
        end
    endtask

    task automatic do_rename(input logic [P-1:0] ra, input logic [P-1:0] rb);
        ren_vld = 2'b11; ren_dst = {rb, ra};
        @(negedge clk);
        ren_vld = '0;
    endtask

    // Expected grant: first NG set bits of an eligibility mask.
    function automatic logic [W-1:0] first_n(input logic [W-1:0] m);
        logic [W-1:0] g = '0;
        int c = 0;
        for (int i = 0; i < W; i++) if (m[i] && c < NG) begin g[i] = 1'b1; c++; end
        return g;
    endfunction

    initial begin
        #4000000;
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        clear_win();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 scoreboard clear", sb_state, '0);
        chk("R1 cycle zero", cyc, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 empty window no grant", grant, '0);
        chk("R3 cycle tracks", cyc, bcyc);

        // R2: rename sets -1
        do_rename(4'd15, 4'd3);
        chk("R2 reg15 pending", sbv(15), 3'b111);
        chk("R2 reg3 pending", sbv(3), 3'b111);

        // R5: pending source blocks, invalid source ignored
        slot_vld = 8'b011;
        b_svld[0] = 3'b001; b_src[0][0] = 4'd3;
        b_svld[1] = 3'b001; b_src[1][0] = 4'd0; b_src[1][1] = 4'd15;
        #1 chk("R5 pending src blocks, invalid src ignored", grant, 8'b010);
        @(negedge clk); clear_win();

        // R3/R4: ALU dst 3 and load dst 4 issue together
        slot_vld = 8'b011; slot_load = 8'b010;
        b_dvld[0] = 2'b01; b_dst[0][0] = 4'd3;
        b_dvld[1] = 2'b01; b_dst[1][0] = 4'd4;
        #1;
        chk("R3 both granted", grant, 8'b011);
        chk("R3 alu done cycle", grant_done_at[0 +: C], C'(bcyc + 1));
        chk("R3 load done cycle", grant_done_at[C +: C], C'(bcyc + 3));
        @(negedge clk); clear_win();
        chk("R3 alu dst reads zero", sbv(3), 3'd0);
        chk("R3 load dst reads two", sbv(4), 3'd2);
        @(negedge clk);
        chk("R4 load dst falls to one", sbv(4), 3'd1);
        @(negedge clk);
        chk("R4 load dst falls to zero", sbv(4), 3'd0);
        @(negedge clk);
        chk("R4 zero holds", sbv(4), 3'd0);
        chk("R4 negative holds", sbv(15), 3'b111);

        // R11: rename beats decay and same-cycle issue
        slot_vld = 8'b001; slot_load = 8'b001;
        b_dvld[0] = 2'b01; b_dst[0][0] = 4'd5;
        @(negedge clk); clear_win();
        chk("R3 load dst 5 reads two", sbv(5), 3'd2);
        slot_vld = 8'b001; b_dvld[0] = 2'b01; b_dst[0][0] = 4'd6;
        do_rename(4'd5, 4'd6);
        clear_win();
        chk("R11 rename over decay", sbv(5), 3'b111);
        chk("R11 rename over issue", sbv(6), 3'b111);

        // R6 sweep: every eligibility mask, blocked slots read reg 15
        for (int m = 0; m < 256; m++) begin
            clear_win();
            slot_vld = '1;
            for (int i = 0; i < W; i++) begin
                b_svld[i] = 3'b001;
                b_src[i][0] = m[i] ? 4'd0 : 4'd15;
            end
            #1 chk($sformatf("R6 oldest first mask %0h", m), grant, first_n(8'(m)));
            @(negedge clk);
        end

        // R10 sweep: valid and issued masks
        for (int m = 0; m < 256; m++) begin
            logic [W-1:0] v, is;
            clear_win();
            v = 8'(m); is = {v[2:0], v[7:3]} ^ 8'h5A;
            slot_vld = v; slot_issued = is;
            #1 chk($sformatf("R10 valid %0h issued %0h", v, is), grant, first_n(v & ~is));
            @(negedge clk);
        end

        // R7/R8/R9 sweep: mode x store state x address relation
        for (int md = 0; md < 4; md++) begin
            for (int st = 0; st < 4; st++) begin
                for (int same = 0; same < 2; same++) begin
                    logic exp_ld;
                    logic done_st;
                    clear_win();
                    ord_mode = 2'(md);
                    slot_vld = 8'b111; slot_store = 8'b101; slot_load = 8'b010;
                    b_svld[0] = 3'b001; b_src[0][0] = 4'd15;
                    b_svld[2] = 3'b001; b_src[2][0] = 4'd15;
                    b_addr[0] = 16'h1230; b_addr[2] = 16'h4440;
                    b_addr[1] = same ? 16'h1230 : 16'h4440;
                    // st: 0 not issued, 1 issued pending, 2 done now, 3 done earlier
                    slot_issued[0] = (st != 0);
                    b_done[0] = (st == 1) ? C'(bcyc + 1) : (st == 2) ? bcyc : C'(bcyc - 1);
                    done_st = (st >= 2);
                    exp_ld = (md == 0) || done_st || (md == 2 && !same);
                    #1 chk($sformatf("R7 R8 R9 mode %0d store %0d same %0d", md, st, same),
                           grant, {5'b0, 1'b0, exp_ld, 1'b0});
                    @(negedge clk);
                end
            end
        end

        clear_win();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule